// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a down-counting watchdog with a two-step escalation. While it runs it decrements once per clock. When it passes zero it reloads from the programmed load value. The first expiry marks an interrupt as pending. A second expiry that arrives while that interrupt has not been cleared produces a reset pulse, provided reset generation is enabled.

Software services the watchdog by clearing the interrupt, which also reloads the counter. A key-protected lock shields the load, control and clear registers from stray writes. A stall option freezes the count while a debug halt input is high.

Access is through a simple single-cycle write strobe with an address and data. Read data is combinational from the address.

Top module: `wdog_top`

## Requirements
- R1: After reset the count and load registers read 0xFFFFFFFF, control reads 0, the block is unlocked (lock register reads 0), and `irq_o` and `wd_rst_o` are low.
- R2: The count register (address 1) decrements by one per clock while the run bit (control bit 0) is set. It holds its value while the run bit is clear.
- R3: When the counter is at zero on a counting clock, it reloads from the load register. If no interrupt was pending, the pending flag (status register at address 4, bit 0) is set from the next cycle on.
- R4: An expiry that occurs while the interrupt is pending and reset enable (control bit 1) is set drives `wd_rst_o` high for exactly one cycle, starting in the next cycle. The same expiry clears the pending flag and reloads the counter.
- R5: With reset enable clear, repeated expiries never assert `wd_rst_o`, and the pending flag stays set.
- R6: `irq_o` is high exactly when the pending flag is set and the interrupt enable (control bit 3) is set.
- R7: Any write to the clear register (address 3) clears the pending flag and reloads the counter from the load register. It takes priority over an expiry in the same cycle.
- R8: A write to the load register (address 0) stores the value and loads it into the counter on the same clock edge.
- R9: Writing the key 0x5EC00D1E to the lock register (address 5) unlocks the block, and writing any other value locks it. The lock register reads 1 while locked. While locked, writes to addresses 0, 2 and 3 are ignored.
- R10: While the stall bit (control bit 2) and `halt_i` are both high, the counter does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, one write per cycle it is high |
| addr_i | input | 3 | Register address for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (unmapped addresses read 0) |
| halt_i | input | 1 | Debug halt request |
| irq_o | output | 1 | Masked timeout interrupt |
| wd_rst_o | output | 1 | Single-cycle reset request |

## Verification
The hardest state to reach from the ports is a second expiry that coincides with other events. These include a clear or load write in the same cycle, a halt that starts or ends on the zero count, and a lock that drops halfway through a service sequence.

Directed sequences first walk through each stage with small load values, so that expiries come every few cycles. A long random phase then uses load values from 0 to 11, frequent halts, random control words, and lock writes that carry the key half of the time. Together these make the coincidences happen many times, and a cycle model in the bench checks every output and every read-back.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_LOAD  = 3'd0,
    A_COUNT = 3'd1,
    A_CTRL  = 3'd2,
    A_ICLR  = 3'd3,
    A_STAT  = 3'd4,
    A_LOCK  = 3'd5
  } addr_e;

  typedef struct packed {
    logic irq_en;
    logic stall_en;
    logic rst_en;
    logic run_en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned       CNT_W    = 32,
  parameter logic [CNT_W-1:0]  KEY      = 32'h5EC0_0D1E,
  parameter logic [CNT_W-1:0]  LOAD_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              pend_i,
  output logic [CNT_W-1:0]  load_o,
  output logic [CNT_W-1:0]  reload_val_o,
  output logic              load_wr_o,
  output logic              irq_clr_o,
  output ctrl_t             ctrl_o,
  output logic              locked_o,
  output logic [CNT_W-1:0]  rdata_o
);
  logic [CNT_W-1:0] load_q;
  ctrl_t            ctrl_q;
  logic             locked_q;
  logic             cfg_ok;
  logic             ctrl_wr;
  logic             lock_wr;

  assign cfg_ok    = wr_en_i && !locked_q;
  assign load_wr_o = cfg_ok && (addr_i == A_LOAD);
  assign irq_clr_o = cfg_ok && (addr_i == A_ICLR);
  assign ctrl_wr   = cfg_ok && (addr_i == A_CTRL);
  // lock register is always writable
  assign lock_wr   = wr_en_i && (addr_i == A_LOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q   <= LOAD_RST;
      ctrl_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      if (load_wr_o) load_q <= wdata_i;
      if (ctrl_wr)   ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (lock_wr)   locked_q <= (wdata_i != KEY);
    end
  end

  // new load value goes straight to the counter on the write edge
  assign reload_val_o = load_wr_o ? wdata_i : load_q;
  assign load_o       = load_q;
  assign ctrl_o       = ctrl_q;
  assign locked_o     = locked_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_LOAD:  rdata_o = load_q;
      A_COUNT: rdata_o = cnt_i;
      A_CTRL:  rdata_o = CNT_W'(ctrl_q);
      A_STAT:  rdata_o = CNT_W'(pend_i);
      A_LOCK:  rdata_o = CNT_W'(locked_q);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned      CNT_W    = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LOAD_RST;
    end else if (reload_i || expire_o) begin
      cnt_q <= reload_val_i;
    end else if (tick_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_i,
  input  logic rst_en_i,
  input  logic irq_en_i,
  output logic pend_o,
  output logic irq_o,
  output logic wd_rst_o
);
  logic pend_q;
  logic rst_q;
  logic second_hit;

  // clear write beats a same-cycle expiry
  assign second_hit = expire_i && pend_q && rst_en_i && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= second_hit;
      if (clr_i)           pend_q <= 1'b0;
      else if (second_hit) pend_q <= 1'b0;
      else if (expire_i)   pend_q <= 1'b1;
    end
  end

  assign pend_o   = pend_q;
  assign irq_o    = pend_q && irq_en_i;
  assign wd_rst_o = rst_q;
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned      CNT_W    = 32,
  parameter logic [CNT_W-1:0] KEY      = 32'h5EC0_0D1E,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              halt_i,
  output logic              irq_o,
  output logic              wd_rst_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] reload_val;
  logic             load_wr;
  logic             irq_clr;
  logic             locked;
  logic             pend;
  logic             tick;
  logic             expire;
  ctrl_t            ctrl;

  assign tick = ctrl.run_en && !(ctrl.stall_en && halt_i);

  wdog_regs #(
    .CNT_W   (CNT_W),
    .KEY     (KEY),
    .LOAD_RST(LOAD_RST)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .cnt_i       (cnt),
    .pend_i      (pend),
    .load_o      (load_q),
    .reload_val_o(reload_val),
    .load_wr_o   (load_wr),
    .irq_clr_o   (irq_clr),
    .ctrl_o      (ctrl),
    .locked_o    (locked),
    .rdata_o     (rdata_o)
  );

  wdog_counter #(
    .CNT_W   (CNT_W),
    .LOAD_RST(LOAD_RST)
  ) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .reload_i    (load_wr || irq_clr),
    .reload_val_i(reload_val),
    .cnt_o       (cnt),
    .expire_o    (expire)
  );

  wdog_escalate u_esc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .expire_i(expire),
    .clr_i   (irq_clr),
    .rst_en_i(ctrl.rst_en),
    .irq_en_i(ctrl.irq_en),
    .pend_o  (pend),
    .irq_o   (irq_o),
    .wd_rst_o(wd_rst_o)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              halt_i,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  load_q,
  input logic              pend,
  input ctrl_t             ctrl,
  input logic              locked,
  input logic              load_wr,
  input logic              irq_clr,
  input logic              wd_rst_o
);
  logic ticking;
  assign ticking = ctrl.run_en && !(ctrl.stall_en && halt_i);

  a_r2_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ticking && (cnt != '0) && !load_wr && !irq_clr |=> cnt == $past(cnt) - 1'b1);

  a_r2_hold_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.run_en && !load_wr && !irq_clr |=> $stable(cnt));

  a_r3_first_sets_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ticking && (cnt == '0) && !pend && !irq_clr |=> pend);

  a_r4_rst_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_rst_o |-> $past(pend) && $past(ctrl.rst_en));

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_rst_o |=> !wd_rst_o);

  a_r5_no_rst_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.rst_en |=> !wd_rst_o);

  a_r7_clear_reloads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr |=> !pend && (cnt == $past(load_q)));

  a_r9_ctrl_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked && wr_en_i && (addr_i == A_CTRL) |=> $stable(ctrl));

  a_r9_load_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked && wr_en_i && (addr_i == A_LOAD) |=> $stable(load_q));

  a_r10_stall_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.run_en && ctrl.stall_en && halt_i && !load_wr && !irq_clr |=> $stable(cnt));
endmodule

bind wdog_top wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .halt_i  (halt_i),
  .cnt     (cnt),
  .load_q  (load_q),
  .pend    (pend),
  .ctrl    (ctrl),
  .locked  (locked),
  .load_wr (load_wr),
  .irq_clr (irq_clr),
  .wd_rst_o(wd_rst_o)
);

// File: tb/wdog_top_tb.sv
module wdog_top_tb;
  localparam logic [31:0] KEY = 32'h5EC0_0D1E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        halt = 1'b0;
  logic [31:0] rdata;
  logic        irq;
  logic        wrst;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit rst_seen = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdog_top #(.CNT_W(32), .KEY(KEY)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .halt_i  (halt),
    .irq_o   (irq),
    .wd_rst_o(wrst)
  );

  // reference model built from the requirements
  logic [31:0] m_cnt, m_load;
  logic [3:0]  m_ctrl; // {irq_en, stall_en, rst_en, run_en}
  logic        m_lock, m_pend, m_rst;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '1; m_load = '1; m_ctrl = '0; m_lock = 1'b0; m_pend = 1'b0; m_rst = 1'b0;
    end else begin
      bit ok, lw, cl, tk, ex;
      ok = wr_en && !m_lock;
      lw = ok && addr == 3'd0;
      cl = ok && addr == 3'd3;
      tk = m_ctrl[0] && !(m_ctrl[2] && halt);
      ex = tk && m_cnt == 32'd0;
      m_rst = ex && m_pend && m_ctrl[1] && !cl;
      if (cl) m_pend = 1'b0;
      else if (m_rst) m_pend = 1'b0;
      else if (ex) m_pend = 1'b1;
      if (lw) m_cnt = wdata;
      else if (cl || ex) m_cnt = m_load;
      else if (tk) m_cnt = m_cnt - 1;
      if (lw) m_load = wdata;
      if (ok && addr == 3'd2) m_ctrl = wdata[3:0];
      if (wr_en && addr == 3'd5) m_lock = (wdata != KEY);
    end
  end

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_load;
      3'd1: return m_cnt;
      3'd2: return {28'd0, m_ctrl};
      3'd4: return {31'd0, m_pend};
      3'd5: return {31'd0, m_lock};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string read_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R8 load readback";
      3'd1: return "R2 count";
      3'd2: return "R9 ctrl readback";
      3'd4: return "R3 pending";
      3'd5: return "R9 lock status";
      default: return "R1 unmapped read";
    endcase
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  // continuous comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wrst) rst_seen = 1'b1;
      chk({31'd0, irq}, {31'd0, m_pend && m_ctrl[3]}, "R6 irq_o");
      chk({31'd0, wrst}, {31'd0, m_rst}, "R4 wd_rst_o");
      chk(rdata, exp_read(addr), read_tag(addr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog timeout (all requirements)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #2;
    addr = a;
    @(negedge clk);
    chk(rdata, exp, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    rd_chk(3'd1, 32'hFFFF_FFFF, "R1 count after reset");
    rd_chk(3'd0, 32'hFFFF_FFFF, "R1 load after reset");
    rd_chk(3'd2, 32'd0, "R1 ctrl after reset");
    rd_chk(3'd5, 32'd0, "R1 unlocked after reset");
    chk({31'd0, irq}, 32'd0, "R1 irq low");
    chk({31'd0, wrst}, 32'd0, "R1 reset low");

    // R8 load write reloads counter
    wr(3'd0, 32'd20);
    rd_chk(3'd1, 32'd20, "R8 immediate reload");

    // R2 one decrement per cycle
    wr(3'd2, 32'h1);
    rd_chk(3'd1, 32'd19, "R2 first decrement");
    wr(3'd2, 32'h0);
    idle(4);
    rd_chk(3'd1, exp_read(3'd1), "R2 held while stopped");

    // R9 lock and unlock
    wr(3'd0, 32'd20);
    wr(3'd5, 32'd0);
    rd_chk(3'd5, 32'd1, "R9 locked status");
    wr(3'd0, 32'd7);
    rd_chk(3'd0, 32'd20, "R9 load write ignored");
    wr(3'd2, 32'h1);
    rd_chk(3'd2, 32'd0, "R9 ctrl write ignored");
    wr(3'd5, KEY);
    rd_chk(3'd5, 32'd0, "R9 unlocked by key");

    // R10 stall under halt
    wr(3'd0, 32'd10);
    halt = 1'b1;
    wr(3'd2, 32'h5);
    idle(5);
    rd_chk(3'd1, 32'd10, "R10 frozen during halt");
    halt = 1'b0;

    // R3 / R5 / R6 first expiry, reset disabled
    wr(3'd0, 32'd3);
    rst_seen = 1'b0;
    wr(3'd2, 32'h9);
    idle(25);
    @(negedge clk);
    chk({31'd0, irq}, 32'd1, "R6 irq visible when enabled");
    chk({31'd0, rst_seen}, 32'd0, "R5 no reset when disabled");
    wr(3'd2, 32'h0);
    rd_chk(3'd4, 32'd1, "R3 pending after expiry");

    // R7 clear reloads and clears pending
    wr(3'd3, 32'd0);
    rd_chk(3'd4, 32'd0, "R7 pending cleared");
    rd_chk(3'd1, 32'd3, "R7 counter reloaded");

    // R4 second expiry gives reset
    rst_seen = 1'b0;
    wr(3'd2, 32'hB);
    idle(20);
    chk({31'd0, rst_seen}, 32'd1, "R4 reset pulse seen");

    // R6 masked interrupt
    wr(3'd3, 32'd0);
    wr(3'd2, 32'h1);
    idle(10);
    @(negedge clk);
    chk({31'd0, irq}, 32'd0, "R6 irq masked");
    wr(3'd2, 32'h0);
    rd_chk(3'd4, 32'd1, "R6 pending while masked");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #2;
      halt = ($urandom % 4) == 0;
      addr = 3'($urandom % 8);
      if (($urandom % 6) == 0) begin
        wr_en = 1'b1;
        case (addr)
          3'd0: wdata = $urandom % 12;
          3'd2: wdata = (($urandom % 4) != 0) ? (($urandom % 16) | 32'h1) : ($urandom % 16);
          3'd5: wdata = ($urandom % 2) ? KEY : $urandom;
          default: wdata = $urandom;
        endcase
      end else begin
        wr_en = 1'b0;
      end
    end
    @(posedge clk); #2;
    wr_en = 1'b0;
    idle(2);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule